// File: doc/BRIEF.md
# DMA Channel Request Flow Controller

This block is the flow-control engine for one channel of a DMA controller. It decides when each transfer of the channel begins and how many beats it carries. The decision depends on the transfer direction, on the number of beats still owed, and on two handshake lines from the peripheral: a burst request and a single request. Each transfer is announced by a one-cycle start command, either a burst start or a single start, together with a beat count. A bus model returns one beat-complete strobe per beat moved. When a request-triggered transfer ends, the block pulses an acknowledge back to the peripheral. When the whole programmed count has moved, it pulses channel done.

Three directions are supported. For peripheral-to-memory, full bursts are taken on the burst request while enough data remains. The tail is then taken one beat at a time on the single request. For memory-to-peripheral, only the burst request is used, and the tail is moved as one shorter final transfer. For memory-to-memory, transfers start without any request, in burst-sized pieces with a shorter tail, until the count is used up or software drops the enable. The configuration is captured when an idle channel sees its enable high.

Top module: `dmaFlowCtrl`

## Requirements
- R1: After reset, startBurst, startSingle, clrAck and chanDone are all low, and no transfer starts while chanEn is low.
- R2: With xferMode = 2'b00 (peripheral-to-memory) and remaining count at or above the burst length, a high burstReq starts a burst of exactly the burst length beats. This holds even if singleReq is high at the same time. singleReq alone starts nothing.
- R3: With xferMode = 2'b00 and remaining count below the burst length, a high singleReq starts a single transfer with xferBeats = 1, whatever burstReq does. burstReq alone starts nothing.
- R4: With xferMode = 2'b01 (memory-to-peripheral), singleReq never starts a transfer. A high burstReq with remaining count at or above the burst length starts a full burst.
- R5: With xferMode = 2'b01 and a nonzero remaining count below the burst length, a high burstReq starts one burst whose xferBeats equals the remaining count.
- R6: A remaining count exactly equal to the burst length is handled as a full burst triggered by burstReq, in both request-driven modes.
- R7: With xferMode[1] = 1 (memory-to-memory), transfers start with no request: each one has min(remaining, burst length) beats, and clrAck is never pulsed.
- R8: One cycle after the final beatDone of a request-triggered transfer, clrAck is high for exactly one cycle. Requests held high during a transfer or during that acknowledge cycle start nothing.
- R9: When the remaining count reaches zero, chanDone is high for exactly one cycle. No further transfer starts until chanEn has been low and is raised again. A programmed count of zero gives chanDone with no transfer.
- R10: Lowering chanEn during a transfer lets the current beat complete. The channel then returns to idle without chanDone or clrAck, and requests are ignored while chanEn stays low.
- R11: A burst length input of zero is treated as a burst length of one.
- R12: xferMode, totalCount and burstLen are captured when an idle channel sees chanEn high. The remaining count falls by one on every beatDone that is counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| chanEn | input | 1 | Channel enable from software |
| xferMode | input | 2 | 00 peripheral-to-memory, 01 memory-to-peripheral, 1x memory-to-memory |
| totalCount | input | CNT_W | Programmed number of beats |
| burstLen | input | BL_W | Beats per full burst (0 treated as 1) |
| burstReq | input | 1 | Burst request from peripheral |
| singleReq | input | 1 | Single request from peripheral |
| beatDone | input | 1 | One beat completed by the bus model |
| startBurst | output | 1 | One-cycle burst transfer start |
| startSingle | output | 1 | One-cycle single transfer start |
| xferBeats | output | CNT_W | Beat count of the transfer being started |
| clrAck | output | 1 | One-cycle acknowledge to the peripheral |
| chanDone | output | 1 | One-cycle all-data-moved indication |

## Verification
The bench targets the boundary where the remaining count equals the burst length. A design that compares with the wrong inequality would start a single or a short tail there instead of a full burst. It holds the wrong request line high alone in each region. A design that samples both lines would start a transfer that should never happen. It keeps requests high through the transfer and the acknowledge cycle, which catches a second start before the clear. It also drops the enable mid-transfer, where a faulty design would raise done or acknowledge. Finally, it uses a zero burst length and a zero count, which would hang or underflow a design that takes those values at face value.

// File: rtl/dmaFlowPkg.sv
package dmaFlowPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ISSUE,
    ST_XFER,
    ST_ACK,
    ST_DONE,
    ST_HOLD
  } flowState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // capture configuration, reset remaining count
    logic issueFull;  // next transfer carries a full burst
    logic issueTail;  // next transfer carries every remaining beat
    logic issueOne;   // next transfer carries one beat
    logic beat;       // one beat completed
  } flowStrobe_t;

  localparam logic [1:0] MODE_P2M = 2'b00;
  localparam logic [1:0] MODE_M2P = 2'b01;

endpackage

// File: rtl/dmaFlowDatapath.sv
module dmaFlowDatapath
  import dmaFlowPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BL_W  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  flowStrobe_t      strobe,
  input  logic [1:0]       xferMode,
  input  logic [CNT_W-1:0] totalCount,
  input  logic [BL_W-1:0]  burstLen,
  output logic [1:0]       cfgMode,
  output logic             remZero,
  output logic             remGeBurst,
  output logic             lastBeat,
  output logic [CNT_W-1:0] xferBeats
);

  localparam int PAD_W = CNT_W - BL_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] remCnt;
  logic [CNT_W-1:0] beatsLeft;
  logic [CNT_W-1:0] cfgBurst;
  logic [CNT_W-1:0] issueBeats;
  logic [CNT_W-1:0] burstExt;
  logic [CNT_W-1:0] nextBeats;
  logic             anyIssue;

  assign burstExt = {{PAD_W{1'b0}}, burstLen};
  assign anyIssue = strobe.issueFull | strobe.issueTail | strobe.issueOne;

  always_comb begin
    nextBeats = issueBeats;
    if (strobe.issueFull)      nextBeats = cfgBurst;
    else if (strobe.issueTail) nextBeats = remCnt;
    else if (strobe.issueOne)  nextBeats = ONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remCnt     <= '0;
      beatsLeft  <= '0;
      cfgBurst   <= ONE;
      cfgMode    <= MODE_P2M;
      issueBeats <= '0;
    end else begin
      if (strobe.load) begin
        remCnt   <= totalCount;
        cfgBurst <= (burstExt == '0) ? ONE : burstExt;
        cfgMode  <= xferMode;
      end else if (strobe.beat) begin
        remCnt <= remCnt - ONE;
      end
      if (anyIssue) begin
        issueBeats <= nextBeats;
        beatsLeft  <= nextBeats;
      end else if (strobe.beat) begin
        beatsLeft <= beatsLeft - ONE;
      end
    end
  end

  assign remZero    = (remCnt == '0);
  assign remGeBurst = (remCnt >= cfgBurst);
  assign lastBeat   = (beatsLeft == ONE);
  assign xferBeats  = issueBeats;

  // R5: an issued transfer is never empty and never exceeds what remains
  a_r5_beats_bounded: assert property (@(posedge clk) disable iff (!rstN)
    anyIssue |=> (issueBeats != '0) && (issueBeats <= remCnt));

  // R12: a counted beat never underflows the remaining count
  a_r12_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.beat |-> !remZero);

  // R11: a captured burst length is never zero
  a_r11_burst_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (cfgBurst != '0));

endmodule

// File: rtl/dmaFlowControl.sv
module dmaFlowControl
  import dmaFlowPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        chanEn,
  input  logic        burstReq,
  input  logic        singleReq,
  input  logic        beatDone,
  input  logic [1:0]  cfgMode,
  input  logic        remZero,
  input  logic        remGeBurst,
  input  logic        lastBeat,
  output flowStrobe_t strobe,
  output logic        startBurst,
  output logic        startSingle,
  output logic        clrAck,
  output logic        chanDone
);

  flowState_t state, stateNext;
  logic       issueSingle, issueSingleNext;
  logic       isM2m, isP2m;

  assign isM2m = cfgMode[1];
  assign isP2m = (cfgMode == MODE_P2M);

  always_comb begin
    stateNext       = state;
    issueSingleNext = issueSingle;
    strobe          = '0;
    unique case (state)
      ST_IDLE: begin
        if (chanEn) begin
          strobe.load = 1'b1;
          stateNext   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!chanEn) begin
          stateNext = ST_IDLE;
        end else if (remZero) begin
          stateNext = ST_DONE;
        end else if (isM2m) begin
          strobe.issueFull = remGeBurst;
          strobe.issueTail = !remGeBurst;
          issueSingleNext  = 1'b0;
          stateNext        = ST_ISSUE;
        end else if (isP2m) begin
          if (remGeBurst) begin
            if (burstReq) begin
              strobe.issueFull = 1'b1;
              issueSingleNext  = 1'b0;
              stateNext        = ST_ISSUE;
            end
          end else if (singleReq) begin
            strobe.issueOne = 1'b1;
            issueSingleNext = 1'b1;
            stateNext       = ST_ISSUE;
          end
        end else if (burstReq) begin
          strobe.issueFull = remGeBurst;
          strobe.issueTail = !remGeBurst;
          issueSingleNext  = 1'b0;
          stateNext        = ST_ISSUE;
        end
      end
      ST_ISSUE: stateNext = ST_XFER;
      ST_XFER: begin
        if (beatDone) begin
          strobe.beat = 1'b1;
          if (!chanEn)       stateNext = ST_IDLE;
          else if (lastBeat) stateNext = isM2m ? ST_WAIT : ST_ACK;
        end
      end
      ST_ACK:  stateNext = ST_WAIT;
      ST_DONE: stateNext = ST_HOLD;
      ST_HOLD: if (!chanEn) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      issueSingle <= 1'b0;
    end else begin
      state       <= stateNext;
      issueSingle <= issueSingleNext;
    end
  end

  assign startBurst  = (state == ST_ISSUE) && !issueSingle;
  assign startSingle = (state == ST_ISSUE) && issueSingle;
  assign clrAck      = (state == ST_ACK);
  assign chanDone    = (state == ST_DONE);

  // R1: at most one command or indication at a time
  a_r1_outputs_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({startBurst, startSingle, clrAck, chanDone}));

  // R8: final beat of a request-triggered transfer is followed by the acknowledge
  a_r8_ack_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XFER && beatDone && lastBeat && chanEn && !isM2m) |=> clrAck);

  // R8: the acknowledge lasts one cycle
  a_r8_ack_pulse: assert property (@(posedge clk) disable iff (!rstN)
    clrAck |=> !clrAck);

  // R9: done lasts one cycle and no start follows it directly
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    chanDone |=> !chanDone && !startBurst && !startSingle);

  // R7: memory-to-memory transfers never acknowledge
  a_r7_m2m_no_ack: assert property (@(posedge clk) disable iff (!rstN)
    isM2m |-> !clrAck);

  // R10: an aborted transfer gives neither done nor acknowledge
  a_r10_abort_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_XFER && beatDone && !chanEn) |=> !chanDone && !clrAck);

  // R3: single transfers only in peripheral-to-memory mode
  a_r3_single_p2m: assert property (@(posedge clk) disable iff (!rstN)
    startSingle |-> isP2m);

endmodule

// File: rtl/dmaFlowCtrl.sv
module dmaFlowCtrl
  import dmaFlowPkg::*;
#(
  parameter int CNT_W = 16,
  parameter int BL_W  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             chanEn,
  input  logic [1:0]       xferMode,
  input  logic [CNT_W-1:0] totalCount,
  input  logic [BL_W-1:0]  burstLen,
  input  logic             burstReq,
  input  logic             singleReq,
  input  logic             beatDone,
  output logic             startBurst,
  output logic             startSingle,
  output logic [CNT_W-1:0] xferBeats,
  output logic             clrAck,
  output logic             chanDone
);

  flowStrobe_t strobe;
  logic [1:0]  cfgMode;
  logic        remZero, remGeBurst, lastBeat;

  dmaFlowControl u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .chanEn      (chanEn),
    .burstReq    (burstReq),
    .singleReq   (singleReq),
    .beatDone    (beatDone),
    .cfgMode     (cfgMode),
    .remZero     (remZero),
    .remGeBurst  (remGeBurst),
    .lastBeat    (lastBeat),
    .strobe      (strobe),
    .startBurst  (startBurst),
    .startSingle (startSingle),
    .clrAck      (clrAck),
    .chanDone    (chanDone)
  );

  dmaFlowDatapath #(
    .CNT_W (CNT_W),
    .BL_W  (BL_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .xferMode   (xferMode),
    .totalCount (totalCount),
    .burstLen   (burstLen),
    .cfgMode    (cfgMode),
    .remZero    (remZero),
    .remGeBurst (remGeBurst),
    .lastBeat   (lastBeat),
    .xferBeats  (xferBeats)
  );

endmodule

// File: tb/tb_dmaFlowCtrl.sv
module tb_dmaFlowCtrl;

  localparam int CNT_W = 16;
  localparam int BL_W  = 5;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             chanEn = 1'b0;
  logic [1:0]       xferMode = 2'b00;
  logic [CNT_W-1:0] totalCount = '0;
  logic [BL_W-1:0]  burstLen = '0;
  logic             burstReq = 1'b0;
  logic             singleReq = 1'b0;
  logic             beatDone = 1'b0;
  logic             startBurst, startSingle, clrAck, chanDone;
  logic [CNT_W-1:0] xferBeats;

  int nChecks = 0;
  int nFail   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dmaFlowCtrl #(.CNT_W(CNT_W), .BL_W(BL_W)) dut (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .xferMode(xferMode),
    .totalCount(totalCount), .burstLen(burstLen), .burstReq(burstReq),
    .singleReq(singleReq), .beatDone(beatDone), .startBurst(startBurst),
    .startSingle(startSingle), .xferBeats(xferBeats), .clrAck(clrAck),
    .chanDone(chanDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int effBurst(input int b);
    return (b == 0) ? 1 : b;
  endfunction

  function automatic int expBeats(input int mode, input int rem, input int b);
    if (rem >= effBurst(b)) return effBurst(b);
    if (mode == 0) return 1;
    return rem;
  endfunction

  function automatic bit expSingle(input int mode, input int rem, input int b);
    return (mode == 0) && (rem < effBurst(b));
  endfunction

  function automatic string reqTag(input int mode, input int rem, input int b);
    if (mode >= 2) return "R7";
    if (rem == effBurst(b)) return "R6";
    if (mode == 0) return (rem > effBurst(b)) ? "R2" : "R3";
    return (rem > effBurst(b)) ? "R4" : "R5";
  endfunction

  task automatic quietCycles(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      check(!startBurst && !startSingle, req, int'(startBurst | startSingle), 0);
    end
  endtask

  task automatic waitStart(input int limit, output bit found);
    found = 1'b0;
    for (int k = 0; k < limit; k++) begin
      if (startBurst || startSingle) begin
        found = 1'b1;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic runXfer(input int mode, input int total, input int b, input bit rnd);
    int rem;
    bit found;
    xferMode   = mode[1:0];
    totalCount = CNT_W'(total);
    burstLen   = BL_W'(b);
    chanEn     = 1'b1;
    rem        = total;
    @(negedge clk);
    while (rem > 0) begin
      int eb = expBeats(mode, rem, b);
      bit es = expSingle(mode, rem, b);
      string tag = reqTag(mode, rem, b);
      if (mode < 2) begin
        // wrong line alone must be ignored
        if (mode == 1 || !es) singleReq = 1'b1;
        else burstReq = 1'b1;
        quietCycles(3, tag);
        if (es) begin
          singleReq = 1'b1;
          burstReq  = rnd ? 1'($urandom_range(0, 1)) : 1'b0;
        end else begin
          burstReq  = 1'b1;
          singleReq = (mode == 0 && rnd) ? 1'($urandom_range(0, 1)) : 1'b0;
        end
      end
      waitStart(8, found);
      check(found, tag, int'(found), 1);
      if (!found) begin
        rem = 0;
        break;
      end
      check(startSingle == es, tag, int'(startSingle), int'(es));
      check(startBurst == !es, tag, int'(startBurst), int'(!es));
      check(int'(xferBeats) == eb, tag, int'(xferBeats), eb);
      @(negedge clk);
      for (int k = 0; k < eb; k++) begin
        int gap = rnd ? $urandom_range(0, 2) : 0;
        for (int g = 0; g < gap; g++) begin
          check(!startBurst && !startSingle && !clrAck, "R8", int'(startBurst | startSingle | clrAck), 0);
          @(negedge clk);
        end
        check(!startBurst && !startSingle && !clrAck, "R8", int'(startBurst | startSingle | clrAck), 0);
        beatDone = 1'b1;
        @(negedge clk);
        beatDone = 1'b0;
        rem--;
      end
      // one cycle after the final beat: acknowledge for request-driven modes
      if (mode < 2) check(clrAck, "R8", int'(clrAck), 1);
      else          check(!clrAck, "R7", int'(clrAck), 0);
      check(!startBurst && !startSingle, "R8", int'(startBurst | startSingle), 0);
      burstReq  = 1'b0;
      singleReq = 1'b0;
      if (mode < 2) begin
        @(negedge clk);
        check(!clrAck, "R8", int'(clrAck), 0);
      end
    end
    found = 1'b0;
    for (int k = 0; k < 6; k++) begin
      if (chanDone) begin
        found = 1'b1;
        break;
      end
      check(!startBurst && !startSingle, "R9", int'(startBurst | startSingle), 0);
      @(negedge clk);
    end
    check(found, "R9", int'(found), 1);
    burstReq  = 1'b1;
    singleReq = 1'b1;
    @(negedge clk);
    check(!chanDone, "R9", int'(chanDone), 0);
    quietCycles(3, "R9");
    burstReq  = 1'b0;
    singleReq = 1'b0;
    chanEn    = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(150000 * 10);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin : stimulus
    bit found;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check(!startBurst && !startSingle && !clrAck && !chanDone, "R1",
          int'({startBurst, startSingle, clrAck, chanDone}), 0);
    rstN = 1'b1;
    burstReq  = 1'b1;
    singleReq = 1'b1;
    quietCycles(3, "R1");
    burstReq  = 1'b0;
    singleReq = 1'b0;

    // directed corners
    runXfer(0, 8, 4, 1'b0);   // R6 equal boundary, peripheral-to-memory
    runXfer(0, 11, 4, 1'b1);  // R2, R3 tail by singles
    runXfer(1, 10, 4, 1'b0);  // R4, R5 tail of 2
    runXfer(1, 4, 4, 1'b0);   // R6 memory-to-peripheral
    runXfer(2, 9, 4, 1'b1);   // R7 tail of 1
    runXfer(1, 3, 0, 1'b0);   // R11 zero burst length
    runXfer(0, 0, 4, 1'b0);   // R9 zero count
    runXfer(3, 5, 8, 1'b0);   // R7 code 3, single short piece, R12 capture

    // R10: abort in the middle of a burst
    xferMode = 2'b00; totalCount = 16'd8; burstLen = 5'd4; chanEn = 1'b1;
    @(negedge clk);
    burstReq = 1'b1;
    waitStart(8, found);
    check(found && startBurst, "R10", int'(startBurst), 1);
    @(negedge clk);
    chanEn = 1'b0;
    beatDone = 1'b1;
    @(negedge clk);
    beatDone = 1'b0;
    for (int k = 0; k < 5; k++) begin
      check(!chanDone && !clrAck && !startBurst && !startSingle, "R10",
            int'({chanDone, clrAck, startBurst, startSingle}), 0);
      @(negedge clk);
    end
    singleReq = 1'b1;
    quietCycles(3, "R10");
    burstReq = 1'b0; singleReq = 1'b0;
    runXfer(0, 5, 2, 1'b0);   // R12 fresh capture after abort

    // constrained random
    for (int n = 0; n < 40; n++) begin
      runXfer($urandom_range(0, 3), $urandom_range(0, 30), $urandom_range(0, 9), 1'b1);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule